// File: doc/BRIEF.md
# I/O Trap SMI Generator

This block sits on the chipset side of a 386-style local bus and runs at the CLK2 rate. It watches each bus cycle start. A cycle start is a clock edge that samples the address strobe low. The block picks out I/O data cycles and compares their port address against a set of programmable base/mask windows. Each window has a flag that marks its peripheral as powered down. An I/O data cycle that hits a flagged window is trapped, provided the break-enable strap is driven low. The block then drives the active-low system management interrupt low on that same edge and holds off the active-low READY that ends the cycle. The processor therefore samples the interrupt for at least three edges before the edge that completes the cycle, and management mode starts right after the offending instruction. Untrapped I/O data cycles are completed after a short fixed wait. Memory, coprocessor and control cycles are left alone.

Software programs the windows, the powered-down flags and the break-enable bit through a small register port. The same port gives a status register that latches the first trapped address and its direction. The interrupt stays asserted until software writes the clear bit.

Top module: `io_trap_smi_gen`

## Requirements
- R1: After reset, smi_n, ready_n and brk_en_n are high. Every base, mask, control and status register reads zero.
- R2: A cycle start is an I/O data cycle when mio=0, dc=1 and the top address bit is 0. Window i hits when ((addr[15:0] ^ base_i) & mask_i) == 0, where a mask bit of 1 means the bit is compared. A hit traps only when control bit i (the powered-down flag) is 1. The register offsets are: base i at cfg_addr i (0..3), mask i at 4+i, control at 8, status at 9, trapped address at 10.
- R3: A trapped cycle drives smi_n low on the same edge that samples ads_n low.
- R4: For a trapped cycle, ready_n is low for exactly one clock. It goes low after the third edge following the cycle start, so the first edge that samples it low is the fourth edge after smi_n fell.
- R5: For an untrapped I/O data cycle, ready_n is low for exactly one clock, going low after the second edge following the cycle start. smi_n is unchanged.
- R6: Memory cycles (mio=1), control cycles (dc=0) and coprocessor cycles (top address bit 1) produce no smi_n change and no ready_n pulse, whatever the windows hold.
- R7: brk_en_n is the inverse of control bit 4. While bit 4 is 0, no cycle is trapped and a matching I/O data cycle is completed as in R5.
- R8: The status register reads bit 1 = trap pending and bit 0 = direction of the trapped cycle (1 = write). The trapped-address register holds addr[15:0] of the first trap. A further trap while one is pending changes neither register.
- R9: Writing the status register with bit 0 set releases smi_n high and clears the pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CLK2-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ads_n | input | 1 | Address strobe, active low |
| mio | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| dc | input | 1 | 1 = data cycle, 0 = control cycle |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 24 | Bus address; the top bit marks coprocessor cycles |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register select |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data (combinational) |
| smi_n | output | 1 | System management interrupt, active low |
| ready_n | output | 1 | Cycle-ending READY, active low |
| brk_en_n | output | 1 | I/O break-enable strap, active low |

## Verification
A table of bus cycles is run against four programmed windows. The table covers a hit in a flagged window, a hit in an unflagged window, an address inside no window, and the same trapped port issued as a memory, control or coprocessor cycle. The measured READY delay of 3, 2 or no pulse then separates trap timing, plain I/O completion and ignored cycles. Directed sequences cover a second trap that must not overwrite the latched status, the clear write, a matching access with break-enable off (which must fall back to the two-edge wait), and reset wiping the programmed registers.

// File: rtl/io_trap_pkg.sv
package io_trap_pkg;
  // width of the I/O port address compared by the windows
  localparam int IO_W = 16;

  // window match: mask bit 1 = compare this address bit
  function automatic logic win_match(input logic [IO_W-1:0] a,
                                     input logic [IO_W-1:0] base,
                                     input logic [IO_W-1:0] mask);
    return ((a ^ base) & mask) == '0;
  endfunction

  // cycle qualifies for I/O handling: I/O space, data, not coprocessor
  function automatic logic is_io_data(input logic mio, input logic dc,
                                      input logic cop);
    return !mio && dc && !cop;
  endfunction
endpackage

// File: rtl/trap_regs.sv
module trap_regs
  import io_trap_pkg::*;
#(
  parameter int NWIN = 4,
  parameter int RA_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [RA_W-1:0]           cfg_addr,
  input  logic [IO_W-1:0]           cfg_wdata,
  output logic [IO_W-1:0]           cfg_rdata,
  input  logic                      trap_fire,
  input  logic [IO_W-1:0]           trap_addr,
  input  logic                      trap_dir,
  output logic [NWIN-1:0][IO_W-1:0] base_o,
  output logic [NWIN-1:0][IO_W-1:0] mask_o,
  output logic [NWIN-1:0]           pd_o,
  output logic                      brk_en_o,
  output logic                      smi_n
);
  localparam int CTRL_A  = 2 * NWIN;
  localparam int STAT_A  = 2 * NWIN + 1;
  localparam int TADDR_A = 2 * NWIN + 2;
  localparam int BRK_BIT = NWIN;

  logic [NWIN-1:0][IO_W-1:0] base_q, mask_q;
  logic [NWIN-1:0]           pd_q;
  logic                      brk_q, pend_q, dir_q;
  logic [IO_W-1:0]           taddr_q;

  logic clr_req;
  assign clr_req = cfg_we && (int'(cfg_addr) == STAT_A) && cfg_wdata[0];

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[i] <= '0;
        mask_q[i] <= '0;
      end else if (cfg_we) begin
        if (int'(cfg_addr) == i)        base_q[i] <= cfg_wdata;
        if (int'(cfg_addr) == NWIN + i) mask_q[i] <= cfg_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_q  <= '0;
      brk_q <= 1'b0;
    end else if (cfg_we && int'(cfg_addr) == CTRL_A) begin
      pd_q  <= cfg_wdata[NWIN-1:0];
      brk_q <= cfg_wdata[BRK_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      dir_q   <= 1'b0;
      taddr_q <= '0;
    end else if (trap_fire) begin
      pend_q <= 1'b1;
      if (!pend_q) begin
        dir_q   <= trap_dir;
        taddr_q <= trap_addr;
      end
    end else if (clr_req) begin
      pend_q <= 1'b0;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NWIN; i++) begin
      if (int'(cfg_addr) == i)        cfg_rdata = base_q[i];
      if (int'(cfg_addr) == NWIN + i) cfg_rdata = mask_q[i];
    end
    if (int'(cfg_addr) == CTRL_A) begin
      cfg_rdata[NWIN-1:0] = pd_q;
      cfg_rdata[BRK_BIT]  = brk_q;
    end
    if (int'(cfg_addr) == STAT_A)  cfg_rdata[1:0] = {pend_q, dir_q};
    if (int'(cfg_addr) == TADDR_A) cfg_rdata = taddr_q;
  end

  assign base_o   = base_q;
  assign mask_o   = mask_q;
  assign pd_o     = pd_q;
  assign brk_en_o = brk_q;
  assign smi_n    = !pend_q;

  // R9
  clear_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !trap_fire) |=> smi_n);

  // R8
  keep_first_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && trap_fire) |=> ($stable(taddr_q) && $stable(dir_q)));
endmodule

// File: rtl/trap_decode.sv
module trap_decode
  import io_trap_pkg::*;
#(
  parameter int NWIN   = 4,
  parameter int ADDR_W = 24
) (
  input  logic                      ads_n,
  input  logic                      mio,
  input  logic                      dc,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      idle,
  input  logic [NWIN-1:0][IO_W-1:0] base_i,
  input  logic [NWIN-1:0][IO_W-1:0] mask_i,
  input  logic [NWIN-1:0]           pd_i,
  input  logic                      brk_en,
  output logic                      io_start,
  output logic                      trap_hit
);
  logic [NWIN-1:0] win_hit;
  logic            cop;

  assign cop = addr[ADDR_W-1];

  for (genvar i = 0; i < NWIN; i++) begin : g_cmp
    assign win_hit[i] = pd_i[i] && win_match(addr[IO_W-1:0], base_i[i], mask_i[i]);
  end

  assign io_start = !ads_n && idle && is_io_data(mio, dc, cop);
  assign trap_hit = io_start && brk_en && (|win_hit);
endmodule

// File: rtl/trap_timer.sv
module trap_timer #(
  parameter int TRAP_LEAD = 4,
  parameter int IO_WAIT   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic io_start,
  input  logic trap_hit,
  input  logic smi_n,
  output logic ready_n,
  output logic idle
);
  localparam int MAXW  = (TRAP_LEAD - 1 > IO_WAIT) ? TRAP_LEAD - 1 : IO_WAIT;
  localparam int CNT_W = $clog2(MAXW + 1);
  localparam logic [CNT_W-1:0] TRAP_LD = CNT_W'(TRAP_LEAD - 1);
  localparam logic [CNT_W-1:0] IO_LD   = CNT_W'(IO_WAIT);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, trap_cyc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      busy_q     <= 1'b0;
      trap_cyc_q <= 1'b0;
      ready_n    <= 1'b1;
    end else begin
      ready_n <= 1'b1;
      if (io_start) begin
        busy_q     <= 1'b1;
        trap_cyc_q <= trap_hit;
        cnt_q      <= trap_hit ? TRAP_LD : IO_LD;
      end else if (busy_q) begin
        if (cnt_q == CNT_W'(1)) begin
          ready_n <= 1'b0;
          busy_q  <= 1'b0;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign idle = !busy_q;

  // checker: consecutive edges on which smi_n was sampled low
  logic [CNT_W:0] smi_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              smi_run_q <= '0;
    else if (smi_n)          smi_run_q <= '0;
    else if (!(&smi_run_q))  smi_run_q <= smi_run_q + 1'b1;
  end

  // R4
  smi_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_n && trap_cyc_q) |-> (int'(smi_run_q) >= TRAP_LEAD - 1));

  // R5
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_n |=> ready_n);

  // R6
  no_stray_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !io_start) |=> ready_n);
endmodule

// File: rtl/io_trap_smi_gen.sv
module io_trap_smi_gen
  import io_trap_pkg::*;
#(
  parameter int NWIN      = 4,
  parameter int ADDR_W    = 24,
  parameter int TRAP_LEAD = 4,
  parameter int IO_WAIT   = 2,
  parameter int RA_W      = $clog2(2 * NWIN + 3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ads_n,
  input  logic              mio,
  input  logic              dc,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cfg_we,
  input  logic [RA_W-1:0]   cfg_addr,
  input  logic [IO_W-1:0]   cfg_wdata,
  output logic [IO_W-1:0]   cfg_rdata,
  output logic              smi_n,
  output logic              ready_n,
  output logic              brk_en_n
);
  logic [NWIN-1:0][IO_W-1:0] base_w, mask_w;
  logic [NWIN-1:0]           pd_w;
  logic                      brk_en_w, io_start, trap_hit, idle;

  trap_regs #(.NWIN(NWIN), .RA_W(RA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .trap_fire(trap_hit), .trap_addr(addr[IO_W-1:0]), .trap_dir(wr),
    .base_o(base_w), .mask_o(mask_w), .pd_o(pd_w),
    .brk_en_o(brk_en_w), .smi_n(smi_n)
  );

  trap_decode #(.NWIN(NWIN), .ADDR_W(ADDR_W)) u_dec (
    .ads_n(ads_n), .mio(mio), .dc(dc), .addr(addr), .idle(idle),
    .base_i(base_w), .mask_i(mask_w), .pd_i(pd_w), .brk_en(brk_en_w),
    .io_start(io_start), .trap_hit(trap_hit)
  );

  trap_timer #(.TRAP_LEAD(TRAP_LEAD), .IO_WAIT(IO_WAIT)) u_tmr (
    .clk(clk), .rst_n(rst_n),
    .io_start(io_start), .trap_hit(trap_hit), .smi_n(smi_n),
    .ready_n(ready_n), .idle(idle)
  );

  assign brk_en_n = !brk_en_w;

  // R6
  other_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ads_n && idle && (mio || !dc || addr[ADDR_W-1])) |=> !$fell(smi_n));

  // R7
  brk_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_en_n |=> !$fell(smi_n));

  // R3
  trap_smi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_hit |=> !smi_n);
endmodule

// File: tb/tb_io_trap_smi_gen.sv
`timescale 1ns/1ps
module tb_io_trap_smi_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ads_n = 1'b1, mio = 1'b0, dc = 1'b1, wr = 1'b0;
  logic [23:0] addr = '0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        smi_n, ready_n, brk_en_n;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  io_trap_smi_gen dut (
    .clk(clk), .rst_n(rst_n), .ads_n(ads_n), .mio(mio), .dc(dc), .wr(wr),
    .addr(addr), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .smi_n(smi_n), .ready_n(ready_n), .brk_en_n(brk_en_n)
  );

  // {mio, dc, wr, addr[23:0], expect_trap, expect_ready_delay}
  localparam int NV = 8;
  localparam logic [31:0] VEC [NV] = '{
    {1'b0, 1'b1, 1'b0, 24'h000064, 1'b1, 4'd3},  // flagged window 0
    {1'b0, 1'b1, 1'b1, 24'h0003F9, 1'b0, 4'd2},  // unflagged window 1
    {1'b1, 1'b1, 1'b0, 24'h000064, 1'b0, 4'd0},  // memory cycle
    {1'b0, 1'b1, 1'b0, 24'h800064, 1'b0, 4'd0},  // coprocessor cycle
    {1'b0, 1'b0, 1'b0, 24'h000064, 1'b0, 4'd0},  // control cycle
    {1'b0, 1'b1, 1'b1, 24'h000175, 1'b1, 4'd3},  // flagged window 2
    {1'b0, 1'b1, 1'b0, 24'h000300, 1'b0, 4'd2},  // unflagged window 3
    {1'b0, 1'b1, 1'b0, 24'h000080, 1'b0, 4'd2}   // no window
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  // issue one cycle start; report smi_n after the start edge and the ready delay
  task automatic bus_cycle(input logic m, input logic d, input logic w,
                           input logic [23:0] a, output logic smi_after,
                           output int rdy_at, output int rdy_lows);
    @(negedge clk);
    ads_n = 1'b0; mio = m; dc = d; wr = w; addr = a;
    @(negedge clk);
    ads_n = 1'b1;
    smi_after = smi_n;
    rdy_at = 0; rdy_lows = 0;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (!ready_n) begin
        rdy_lows++;
        if (rdy_at == 0) rdy_at = k;
      end
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [15:0] rd;
    logic        s;
    int          at, lows;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(smi_n === 1'b1, "R1 smi_n", smi_n, 1);
    chk(ready_n === 1'b1, "R1 ready_n", ready_n, 1);
    chk(brk_en_n === 1'b1, "R1 brk_en_n", brk_en_n, 1);
    rst_n = 1'b1;
    for (int r = 0; r <= 10; r++) begin
      cfg_read(4'(r), rd);
      chk(rd === 16'h0, "R1 register zero", rd, 0);
    end

    // R2 program windows: base at 0..3, mask at 4..7
    cfg_write(4'd0, 16'h0060); cfg_write(4'd4, 16'hFFF0);
    cfg_write(4'd1, 16'h03F8); cfg_write(4'd5, 16'hFFF8);
    cfg_write(4'd2, 16'h0170); cfg_write(4'd6, 16'hFFF8);
    cfg_write(4'd3, 16'h0300); cfg_write(4'd7, 16'hFFFF);
    cfg_write(4'd8, 16'h0015);  // flags on windows 0 and 2, break enable
    cfg_read(4'd2, rd);
    chk(rd === 16'h0170, "R2 base readback", rd, 16'h0170);
    @(negedge clk);
    chk(brk_en_n === 1'b0, "R7 strap low", brk_en_n, 0);

    for (int v = 0; v < NV; v++) begin
      logic [31:0] e;
      e = VEC[v];
      bus_cycle(e[31], e[30], e[29], e[28:5], s, at, lows);
      chk(s === !e[4], e[4] ? "R3 smi asserted" : "R6 R5 smi unchanged", s, !e[4]);
      chk(at == int'(e[3:0]),
          (e[3:0] == 3) ? "R4 trap ready delay" :
          (e[3:0] == 2) ? "R5 io ready delay" : "R6 no ready", at, e[3:0]);
      chk(lows == ((e[3:0] != 0) ? 1 : 0), "R4 R5 one ready pulse", lows, (e[3:0] != 0));
      if (e[4]) begin
        cfg_write(4'd9, 16'h0001);
        @(negedge clk);
        chk(smi_n === 1'b1, "R9 clear releases smi", smi_n, 1);
      end
    end

    // R8 first trap kept
    bus_cycle(1'b0, 1'b1, 1'b0, 24'h000064, s, at, lows);
    bus_cycle(1'b0, 1'b1, 1'b1, 24'h000171, s, at, lows);
    chk(at == 3, "R4 second trap delay", at, 3);
    cfg_read(4'd9, rd);
    chk(rd === 16'h0002, "R8 status pending read", rd, 2);
    cfg_read(4'd10, rd);
    chk(rd === 16'h0064, "R8 trapped address", rd, 16'h0064);
    cfg_write(4'd9, 16'h0001);
    cfg_read(4'd9, rd);
    chk(rd === 16'h0000, "R9 status cleared", rd, 0);
    bus_cycle(1'b0, 1'b1, 1'b1, 24'h000172, s, at, lows);
    cfg_read(4'd9, rd);
    chk(rd === 16'h0003, "R8 status write dir", rd, 3);
    cfg_write(4'd9, 16'h0001);

    // R7 break disabled
    cfg_write(4'd8, 16'h0005);
    @(negedge clk);
    chk(brk_en_n === 1'b1, "R7 strap high", brk_en_n, 1);
    bus_cycle(1'b0, 1'b1, 1'b0, 24'h000064, s, at, lows);
    chk(s === 1'b1, "R7 no trap", s, 1);
    chk(at == 2, "R7 plain wait", at, 2);

    // R1 reset clears programmed state
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    cfg_read(4'd0, rd);
    chk(rd === 16'h0, "R1 base cleared", rd, 0);
    cfg_read(4'd8, rd);
    chk(rd === 16'h0, "R1 control cleared", rd, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule